// File: doc/BRIEF.md
# Watchdog-Supervised Safe-State Output Controller

This block sits between a supervising host processor and a four-channel analog output path. The host proves it is alive by toggling a pet input; a watchdog counts clock cycles since the last pet edge and, if the programmed limit runs out, forces every output to its programmable safe value and emits a single-cycle reboot request. A sticky flag records that request until the host clears it.

Outside the safe path the block runs a periodic control tick. In closed-loop mode each tick publishes the host's setpoints to an external control law and latches that law's results onto the outputs. In manual mode each tick latches the host-written channel values. Setpoints and manual values are staged in shadow registers and only take effect together at the tick. Several events share one safe path: startup, watchdog expiry, an I/O fault flag, the two host error flags, and four host commands.

Mode state machine states: BOOT (after reset, safe outputs, no command yet), SAFE (safe outputs after any trigger), CTRL (closed-loop), MAN (manual). Transitions: BOOT/SAFE -> CTRL or MAN on a run command when the watchdog is armed and no fault is present; CTRL <-> MAN on the other run command; CTRL/MAN -> SAFE on expiry, any fault flag, or a stop-type command.

Top module: `safe_out_ctrl`

## Requirements
- R1: After reset the mode is BOOT (code 0), every output channel reads 0, the watchdog is not armed, and both the reboot request and the sticky flag are low.
- R2: Each channel has its own safe value (reset 0), written by `safe_wr` with `safe_sel` picking the channel. In BOOT or SAFE the outputs show the safe values from the cycle after a write. Channel k occupies bits [16k+15:16k] of every packed channel bus.
- R3: Only a low-to-high edge on `host_pet` counts as a pet. A pet clears the watchdog count and arms the watchdog. A level that stays high does not re-arm it, and a level already high when reset is released does not count.
- R4: With the watchdog armed and no further pet, the expiry falls on the clock edge `wdt_limit` cycles after the edge that saw the pet. On that edge `reboot_req` rises for exactly one cycle, the watchdog disarms, a running mode goes to SAFE (code 1), and `reboot_sticky` sets and holds until `sticky_clr`.
- R5: Command codes (`cmd_op` with `cmd_valid`): 1 runs closed-loop control (mode code 2), 2 runs manual (mode code 3). A run command leaves BOOT/SAFE only when the watchdog is armed and no fault flag is high; otherwise it is ignored.
- R6: Any of `io_err`, `host_err_crit` or `host_err_minor` high moves a running mode to SAFE on the next edge and blocks run commands.
- R7: Commands 3 (go safe), 4 (stop control), 5 (stop manual) and 6 (exit) move a running mode to SAFE on the next edge.
- R8: While running, a tick falls every `tick_period` cycles, counted from run entry. The outputs keep the safe values captured at entry until the first tick, and `ao_strobe` is high for the cycle after each tick edge.
- R9: In manual mode, each tick copies all four manual shadow values to the outputs together. Shadow writes between ticks leave the outputs unchanged.
- R10: In closed-loop mode, each tick copies the setpoint shadows to `sp_active` and latches `law_in` onto the outputs.
- R11: While running, a safe-value write has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_pet | input | 1 | Watchdog pet level; rising edge counts |
| wdt_limit | input | 32 | Watchdog timeout in cycles (host default 40000) |
| tick_period | input | 32 | Control tick period in cycles (host default 40000) |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| host_err_crit | input | 1 | Host critical error flag |
| host_err_minor | input | 1 | Host non-critical error flag |
| io_err | input | 1 | Converter read/write error flag |
| safe_wr | input | 1 | Safe value write strobe |
| safe_sel | input | 2 | Safe value channel |
| safe_data | input | 16 | Safe value |
| sp_wr | input | 1 | Setpoint shadow write strobe |
| sp_sel | input | 2 | Setpoint channel |
| sp_data | input | 16 | Setpoint value |
| man_wr | input | 1 | Manual shadow write strobe |
| man_sel | input | 2 | Manual channel |
| man_data | input | 16 | Manual value |
| law_in | input | 64 | Control law results, packed per channel |
| sticky_clr | input | 1 | Clears the sticky reboot flag |
| sp_active | output | 64 | Setpoints applied at the last tick |
| ao_data | output | 64 | Output channel values |
| ao_strobe | output | 1 | Outputs updated by a tick |
| mode | output | 2 | Current mode code |
| wdt_armed | output | 1 | Watchdog armed |
| reboot_req | output | 1 | One-cycle reboot request |
| reboot_sticky | output | 1 | Sticky reboot flag |

## Verification
The bench times the watchdog against a pet held high, checking that expiry lands exactly `wdt_limit` edges after the edge that saw the pet. A design that counted levels instead of edges would never expire, and an off-by-one counter would fire a cycle early or late. It tries run commands while the watchdog is unarmed and while a fault is high; a design that ignored either condition would leave safe state. It walks every stop command and every fault flag out of a running mode, and it writes safe values while running, which a wrong output mux would leak straight to the outputs. A random manual phase writes shadow values at arbitrary cycles, including the tick edge itself, so a design that applied shadows at once, or a channel at a time, shows mismatching outputs at the strobe.

// File: rtl/sor_pkg.sv
package sor_pkg;
    typedef enum logic [1:0] {
        M_BOOT = 2'd0,
        M_SAFE = 2'd1,
        M_CTRL = 2'd2,
        M_MAN  = 2'd3
    } sor_mode_e;

    localparam logic [2:0] OP_RUN_CTRL = 3'd1;
    localparam logic [2:0] OP_RUN_MAN  = 3'd2;
    localparam logic [2:0] OP_GO_SAFE  = 3'd3;
    localparam logic [2:0] OP_STOP_CTL = 3'd4;
    localparam logic [2:0] OP_STOP_MAN = 3'd5;
    localparam logic [2:0] OP_EXIT     = 3'd6;

    function automatic logic op_is_stop(input logic [2:0] op);
        return (op == OP_GO_SAFE) || (op == OP_STOP_CTL) ||
               (op == OP_STOP_MAN) || (op == OP_EXIT);
    endfunction
endpackage

// File: rtl/sor_watchdog.sv
module sor_watchdog #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pet_lvl,
    input  logic [TW-1:0] limit,
    input  logic          sticky_clr,
    output logic          armed,
    output logic          expire,
    output logic          reboot_req,
    output logic          reboot_sticky
);
    logic          pet_q;
    logic          pet_pulse;
    logic [TW-1:0] cnt;
    logic [TW-1:0] lim_m1;

    assign lim_m1    = (limit == '0) ? '0 : limit - TW'(1);
    assign pet_pulse = pet_lvl & ~pet_q;
    assign expire    = armed & ~pet_pulse & (cnt >= lim_m1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pet_q         <= 1'b1;
            cnt           <= '0;
            armed         <= 1'b0;
            reboot_req    <= 1'b0;
            reboot_sticky <= 1'b0;
        end else begin
            pet_q      <= pet_lvl;
            reboot_req <= expire;
            if (pet_pulse) begin
                cnt   <= '0;
                armed <= 1'b1;
            end else if (expire) begin
                cnt   <= '0;
                armed <= 1'b0;
            end else if (armed) begin
                cnt <= cnt + TW'(1);
            end
            if (expire)
                reboot_sticky <= 1'b1;
            else if (sticky_clr)
                reboot_sticky <= 1'b0;
        end
    end

    // R4: reboot request lasts one cycle and always leaves the sticky flag set
    a_r4_reboot_single: assert property (@(posedge clk) disable iff (!rst_n)
        reboot_req |=> !reboot_req);
    a_r4_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        reboot_req |-> reboot_sticky);
    // R3: a pet level held high cannot re-arm a disarmed watchdog
    a_r3_stuck_pet: assert property (@(posedge clk) disable iff (!rst_n)
        (pet_lvl && pet_q && !armed) |=> !armed);
endmodule

// File: rtl/sor_tick_timer.sv
module sor_tick_timer #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [TW-1:0] period,
    output logic          tick
);
    logic [TW-1:0] cnt;
    logic [TW-1:0] per_m1;

    assign per_m1 = (period == '0) ? '0 : period - TW'(1);
    assign tick   = enable & (cnt >= per_m1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!enable || tick)
            cnt <= '0;
        else
            cnt <= cnt + TW'(1);
    end

    // R8: the first cycle of a run never ticks when the period exceeds one
    a_r8_no_tick_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !$past(enable) && period > TW'(1)) |-> !tick);
endmodule

// File: rtl/sor_mode_fsm.sv
module sor_mode_fsm
    import sor_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic       fault,
    input  logic       wdt_expire,
    input  logic       wdt_armed,
    output sor_mode_e  state,
    output logic       running,
    output logic       ctrl_sel
);
    sor_mode_e state_n;
    logic      want_ctrl;
    logic      want_man;
    logic      want_stop;

    assign want_ctrl = cmd_valid && (cmd_op == OP_RUN_CTRL);
    assign want_man  = cmd_valid && (cmd_op == OP_RUN_MAN);
    assign want_stop = cmd_valid && op_is_stop(cmd_op);

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= M_BOOT;
        else
            state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            M_BOOT, M_SAFE: begin
                if (wdt_armed && !fault && !wdt_expire) begin
                    if (want_ctrl)
                        state_n = M_CTRL;
                    else if (want_man)
                        state_n = M_MAN;
                end
            end
            M_CTRL: begin
                if (wdt_expire || fault || want_stop)
                    state_n = M_SAFE;
                else if (want_man)
                    state_n = M_MAN;
            end
            M_MAN: begin
                if (wdt_expire || fault || want_stop)
                    state_n = M_SAFE;
                else if (want_ctrl)
                    state_n = M_CTRL;
            end
            default: state_n = M_SAFE;
        endcase
    end

    always_comb begin
        running  = (state == M_CTRL) || (state == M_MAN);
        ctrl_sel = (state == M_CTRL);
    end

    // R4: watchdog expiry ends a run
    a_r4_expire_to_safe: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_expire && running) |=> (state == M_SAFE));
    // R6: a fault flag never leaves the block running on the next cycle
    a_r6_fault_safe: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !running);
    // R5: entering a run requires an armed watchdog
    a_r5_entry_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !$past(running)) |-> $past(wdt_armed));
    // R7: stop-type commands end a run
    a_r7_stop_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (want_stop && running) |=> (state == M_SAFE));
endmodule

// File: rtl/sor_chan_bank.sv
module sor_chan_bank #(
    parameter int NCH = 4,
    parameter int DW  = 16,
    parameter int SW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              safe_wr,
    input  logic [SW-1:0]     safe_sel,
    input  logic [DW-1:0]     safe_data,
    input  logic              sp_wr,
    input  logic [SW-1:0]     sp_sel,
    input  logic [DW-1:0]     sp_data,
    input  logic              man_wr,
    input  logic [SW-1:0]     man_sel,
    input  logic [DW-1:0]     man_data,
    input  logic [NCH*DW-1:0] law_in,
    input  logic              running,
    input  logic              ctrl_sel,
    input  logic              tick,
    output logic [NCH*DW-1:0] sp_active,
    output logic [NCH*DW-1:0] ao_data,
    output logic              ao_strobe
);
    logic [DW-1:0] safe_q [NCH];
    logic [DW-1:0] man_q  [NCH];
    logic [DW-1:0] sp_q   [NCH];
    logic [DW-1:0] spa_q  [NCH];
    logic [DW-1:0] run_q  [NCH];

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                safe_q[k] <= '0;
                man_q[k]  <= '0;
                sp_q[k]   <= '0;
                spa_q[k]  <= '0;
                run_q[k]  <= '0;
            end else begin
                if (safe_wr && safe_sel == SW'(k))
                    safe_q[k] <= safe_data;
                if (man_wr && man_sel == SW'(k))
                    man_q[k] <= man_data;
                if (sp_wr && sp_sel == SW'(k))
                    sp_q[k] <= sp_data;
                if (tick)
                    spa_q[k] <= sp_q[k];
                if (!running)
                    run_q[k] <= safe_q[k];
                else if (tick)
                    run_q[k] <= ctrl_sel ? law_in[k*DW +: DW] : man_q[k];
            end
        end
        assign ao_data[k*DW +: DW]   = running ? run_q[k] : safe_q[k];
        assign sp_active[k*DW +: DW] = spa_q[k];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ao_strobe <= 1'b0;
        else
            ao_strobe <= tick;
    end

    // R9/R11: while running, outputs move only on a tick strobe
    a_r9_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && !ao_strobe) |-> $stable(ao_data));
    // R10: a closed-loop tick lands the law results on the outputs
    a_r10_law_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (ao_strobe && running && $past(running) && $past(ctrl_sel)) |-> (ao_data == $past(law_in)));
endmodule

// File: rtl/safe_out_ctrl.sv
module safe_out_ctrl
    import sor_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 16,
    parameter int TW  = 32,
    localparam int SW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_pet,
    input  logic [TW-1:0]     wdt_limit,
    input  logic [TW-1:0]     tick_period,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              host_err_crit,
    input  logic              host_err_minor,
    input  logic              io_err,
    input  logic              safe_wr,
    input  logic [SW-1:0]     safe_sel,
    input  logic [DW-1:0]     safe_data,
    input  logic              sp_wr,
    input  logic [SW-1:0]     sp_sel,
    input  logic [DW-1:0]     sp_data,
    input  logic              man_wr,
    input  logic [SW-1:0]     man_sel,
    input  logic [DW-1:0]     man_data,
    input  logic [NCH*DW-1:0] law_in,
    input  logic              sticky_clr,
    output logic [NCH*DW-1:0] sp_active,
    output logic [NCH*DW-1:0] ao_data,
    output logic              ao_strobe,
    output logic [1:0]        mode,
    output logic              wdt_armed,
    output logic              reboot_req,
    output logic              reboot_sticky
);
    logic      fault;
    logic      wdt_expire;
    logic      running;
    logic      ctrl_sel;
    logic      tick;
    sor_mode_e state;

    assign fault = io_err | host_err_crit | host_err_minor;
    assign mode  = state;

    sor_watchdog #(.TW(TW)) u_wdt (
        .clk           (clk),
        .rst_n         (rst_n),
        .pet_lvl       (host_pet),
        .limit         (wdt_limit),
        .sticky_clr    (sticky_clr),
        .armed         (wdt_armed),
        .expire        (wdt_expire),
        .reboot_req    (reboot_req),
        .reboot_sticky (reboot_sticky)
    );

    sor_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .fault      (fault),
        .wdt_expire (wdt_expire),
        .wdt_armed  (wdt_armed),
        .state      (state),
        .running    (running),
        .ctrl_sel   (ctrl_sel)
    );

    sor_tick_timer #(.TW(TW)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (running),
        .period (tick_period),
        .tick   (tick)
    );

    sor_chan_bank #(.NCH(NCH), .DW(DW), .SW(SW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .safe_wr   (safe_wr),
        .safe_sel  (safe_sel),
        .safe_data (safe_data),
        .sp_wr     (sp_wr),
        .sp_sel    (sp_sel),
        .sp_data   (sp_data),
        .man_wr    (man_wr),
        .man_sel   (man_sel),
        .man_data  (man_data),
        .law_in    (law_in),
        .running   (running),
        .ctrl_sel  (ctrl_sel),
        .tick      (tick),
        .sp_active (sp_active),
        .ao_data   (ao_data),
        .ao_strobe (ao_strobe)
    );

    // R1: the reboot request is never raised while the watchdog is armed
    a_r1_reboot_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        reboot_req |-> !wdt_armed || $past(host_pet) == 1'b0);
endmodule

// File: tb/safe_out_ctrl_tb.sv
module safe_out_ctrl_tb;
    localparam int NCH = 4;
    localparam int DW  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_pet = 1'b0;
    logic [31:0]       wdt_limit = 32'd200;
    logic [31:0]       tick_period = 32'd8;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = 3'd0;
    logic              host_err_crit = 1'b0;
    logic              host_err_minor = 1'b0;
    logic              io_err = 1'b0;
    logic              safe_wr = 1'b0;
    logic [1:0]        safe_sel = 2'd0;
    logic [DW-1:0]     safe_data = '0;
    logic              sp_wr = 1'b0;
    logic [1:0]        sp_sel = 2'd0;
    logic [DW-1:0]     sp_data = '0;
    logic              man_wr = 1'b0;
    logic [1:0]        man_sel = 2'd0;
    logic [DW-1:0]     man_data = '0;
    logic [NCH*DW-1:0] law_in = '0;
    logic              sticky_clr = 1'b0;
    logic [NCH*DW-1:0] sp_active;
    logic [NCH*DW-1:0] ao_data;
    logic              ao_strobe;
    logic [1:0]        mode;
    logic              wdt_armed;
    logic              reboot_req;
    logic              reboot_sticky;

    int n_checks = 0;
    int n_errors = 0;

    logic [DW-1:0] safe_exp [NCH];
    logic [DW-1:0] sp_exp   [NCH];
    logic [DW-1:0] man_exp  [NCH];
    logic [DW-1:0] cap      [NCH];

    always #10 clk = ~clk;

    safe_out_ctrl u_dut (.*);

    function automatic logic [63:0] pack4(input logic [DW-1:0] v [NCH]);
        logic [63:0] r = '0;
        for (int k = 0; k < NCH; k++) r[k*DW +: DW] = v[k];
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chkv(input string tag, input logic [63:0] act, input logic [63:0] exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [2:0] op);
        cmd_valid = 1'b1;
        cmd_op    = op;
        step(1);
        cmd_valid = 1'b0;
        cmd_op    = 3'd0;
    endtask

    task automatic repet();
        host_pet = 1'b0;
        step(1);
        host_pet = 1'b1;
        step(1);
    endtask

    initial begin
        step(100000);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < NCH; k++) begin
            safe_exp[k] = '0; sp_exp[k] = '0; man_exp[k] = '0;
        end
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chkv("R1 mode", 64'(mode), 64'd0);
        chkv("R1 ao_data", ao_data, 64'd0);
        chkv("R1 armed", 64'(wdt_armed), 64'd0);
        chkv("R1 reboot", 64'({reboot_req, reboot_sticky}), 64'd0);

        // R2 safe values visible in BOOT
        for (int k = 0; k < NCH; k++) begin
            safe_wr = 1'b1; safe_sel = 2'(k); safe_data = 16'($urandom);
            safe_exp[k] = safe_data;
            step(1);
            safe_wr = 1'b0;
            chkv("R2 safe value shown", ao_data, pack4(safe_exp));
        end

        // R5 run rejected while unarmed
        send_cmd(OP_RUN_MAN_C);
        chkv("R5 unarmed run ignored", 64'(mode), 64'd0);

        // R3 pet edge arms
        host_pet = 1'b1;
        step(1);
        chkv("R3 pet arms", 64'(wdt_armed), 64'd1);

        // R6 fault blocks run
        io_err = 1'b1;
        send_cmd(OP_RUN_CTRL_C);
        io_err = 1'b0;
        chkv("R6 fault blocks run", 64'(mode), 64'd0);

        // R10 / R8 closed-loop tick
        for (int k = 0; k < NCH; k++) begin
            sp_wr = 1'b1; sp_sel = 2'(k); sp_data = 16'($urandom);
            sp_exp[k] = sp_data;
            step(1);
        end
        sp_wr = 1'b0;
        law_in = {$urandom, $urandom};
        send_cmd(OP_RUN_CTRL_C);
        chkv("R5 run control", 64'(mode), 64'd2);
        step(7);
        chkv("R8 safe until first tick", ao_data, pack4(safe_exp));
        chkv("R8 no strobe before tick", 64'(ao_strobe), 64'd0);
        step(1);
        chkv("R8 strobe at tick", 64'(ao_strobe), 64'd1);
        chkv("R10 law latched", ao_data, law_in);
        chkv("R10 setpoints applied", sp_active, pack4(sp_exp));

        // R11 safe write while running is invisible
        safe_wr = 1'b1; safe_sel = 2'd2; safe_data = 16'hA5C3; safe_exp[2] = 16'hA5C3;
        step(1);
        safe_wr = 1'b0;
        chkv("R11 safe write ignored", ao_data, law_in);

        // R7 stop commands
        for (int op = 3; op <= 6; op++) begin
            repet();
            send_cmd(OP_RUN_CTRL_C);
            chkv("R7 running before stop", 64'(mode), 64'd2);
            send_cmd(3'(op));
            chkv("R7 stop command", 64'(mode), 64'd1);
            chkv("R2 safe shown after stop", ao_data, pack4(safe_exp));
        end

        // R6 each fault flag
        for (int f = 0; f < 3; f++) begin
            repet();
            send_cmd(OP_RUN_MAN_C);
            chkv("R6 running before fault", 64'(mode), 64'd3);
            io_err = (f == 0); host_err_crit = (f == 1); host_err_minor = (f == 2);
            step(1);
            io_err = 1'b0; host_err_crit = 1'b0; host_err_minor = 1'b0;
            chkv("R6 fault to safe", 64'(mode), 64'd1);
        end

        // R4 watchdog expiry with pet stuck high
        wdt_limit = 32'd20;
        repet();
        send_cmd(OP_RUN_MAN_C);
        chkv("R4 running", 64'(mode), 64'd3);
        step(18);
        chkv("R4 no early reboot", 64'(reboot_req), 64'd0);
        chkv("R3 stuck pet still running", 64'(mode), 64'd3);
        step(1);
        chkv("R4 reboot pulse", 64'(reboot_req), 64'd1);
        chkv("R4 mode safe", 64'(mode), 64'd1);
        chkv("R4 sticky set", 64'(reboot_sticky), 64'd1);
        chkv("R4 disarmed", 64'(wdt_armed), 64'd0);
        step(1);
        chkv("R4 pulse single cycle", 64'(reboot_req), 64'd0);
        send_cmd(OP_RUN_CTRL_C);
        chkv("R3 stuck pet no rearm", 64'(mode), 64'd1);
        chkv("R4 sticky holds", 64'(reboot_sticky), 64'd1);
        sticky_clr = 1'b1;
        step(1);
        sticky_clr = 1'b0;
        chkv("R4 sticky cleared", 64'(reboot_sticky), 64'd0);

        // R9 random manual phase
        wdt_limit = 32'd50;
        tick_period = 32'd5;
        repet();
        send_cmd(OP_RUN_MAN_C);
        chkv("R9 run manual", 64'(mode), 64'd3);
        for (int j = 1; j <= 150; j++) begin
            bit is_tick;
            is_tick = (j % 5) == 0;
            host_pet = (j % 10) >= 5;
            if (is_tick) for (int k = 0; k < NCH; k++) cap[k] = man_exp[k];
            man_wr = 1'($urandom);
            man_sel = 2'($urandom);
            man_data = 16'($urandom);
            if (man_wr) man_exp[man_sel] = man_data;
            step(1);
            chkv("R8 strobe timing", 64'(ao_strobe), 64'(is_tick));
            if (is_tick) chkv("R9 manual atomic", ao_data, pack4(cap));
        end
        man_wr = 1'b0;
        chkv("R9 still manual", 64'(mode), 64'd3);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    localparam logic [2:0] OP_RUN_CTRL_C = 3'd1;
    localparam logic [2:0] OP_RUN_MAN_C  = 3'd2;
endmodule